// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from normal execution into an exception handler. It takes one request, of five kinds: reset, interrupt at a priority level, bus error, address error, or trap with a trap number. With the request it samples the live status word, program counter and supervisor stack pointer. It then runs a fixed sequence. First it keeps a copy of the status word and switches the live one to supervisor mode with tracing off. Next it resolves the vector number. Then it pushes the saved context onto the supervisor stack. Last it reads the handler address from the vector table.

Memory traffic goes over a single word-wide master port. Each access raises a request and holds it until an acknowledge comes back. Interrupt vectors come from a separate acknowledge handshake that returns a vector number. When the new program counter is in place, the block pulses `done`. The new status word, stack pointer and program counter are then valid on its outputs.

The kind is encoded on `kind` as: 0 reset, 1 interrupt, 2 bus error, 3 address error, 4 trap.

Top module: `exc_entry_seq`

## Requirements
- R1: When `done` pulses, `sr_out` has the supervisor bit (bit 13) set and the trace bit (bit 15) clear. For kinds other than reset, all other bits outside the mask field (bits 10:8) equal `sr_in` as sampled at the accepted `start`.
- R2: The mask field, bits 10:8 of `sr_out`, becomes 7 for reset and `irq_level` for an interrupt. For bus error, address error and trap it keeps the sampled value.
- R3: An interrupt raises `iack_req` with `iack_level` equal to the serviced level, exactly once, and takes the vector number from `iack_vector` in the cycle `iack_ack` is high. No other kind raises `iack_req`, and `iack_req` is never high together with `mem_req`.
- R4: Vector numbers for the other kinds are fixed: reset 0 and 1, bus error 2, address error 3, trap 32 + `trap_num`.
- R5: The vector address is the vector number times four. The handler address is read as two word reads, the high half at the vector address and the low half at vector address + 2.
- R6: Interrupts and traps push a 4-word frame, one word per write, each write at the stack pointer pre-decremented by 2. At the final stack pointer S, the word at S+2i is: i=0 the saved status copy, i=1 PC[31:16], i=2 PC[15:0], i=3 a format word. The format word has format 0000 in bits 15:12 and the vector number times four in bits 11:0. `ssp_out` = `ssp_in` − 8.
- R7: Bus and address errors push a 29-word frame with format 1000. Words 0..3 are laid out as in R6. Word 4 is `fault_info`, word 5 is `fault_addr[31:16]`, word 6 is `fault_addr[15:0]`, and words 7..28 are zero. `ssp_out` = `ssp_in` − 58.
- R8: Reset makes no memory writes and sets `sr_out` to 16'h2700. It loads `ssp_out` from the words at addresses 0 (high half) and 2 (low half), and `pc_out` from the words at 4 and 6.
- R9: A memory request holds its address, direction and write data unchanged until `mem_ack`. Only one access is outstanding at a time, and every address is even.
- R10: `done` is a single-cycle pulse. After it, `busy` is low, and `sr_out`, `ssp_out` and `pc_out` hold their values until the next accepted `start`. After reset, `busy`, `mem_req`, `iack_req` and `done` are low.
- R11: A `start` of kind reset is accepted even while busy. It abandons the sequence in progress and finishes as a plain reset entry (R8).
- R12: A `start` of any other kind while busy is ignored. The running sequence completes with the values sampled when it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Exception request strobe |
| kind | input | 3 | Exception kind code |
| irq_level | input | 3 | Priority level of an interrupt request |
| trap_num | input | 4 | Trap number for kind trap |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Current program counter |
| ssp_in | input | 32 | Current supervisor stack pointer |
| fault_addr | input | 32 | Faulting address for bus/address errors |
| fault_info | input | 16 | Fault description word for bus/address errors |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word |
| mem_ack | input | 1 | Memory access complete |
| iack_req | output | 1 | Interrupt acknowledge request |
| iack_level | output | 3 | Level being acknowledged |
| iack_ack | input | 1 | Interrupt acknowledge complete |
| iack_vector | input | 8 | Vector number returned by the acknowledge |
| sr_out | output | 16 | New status word |
| ssp_out | output | 32 | New supervisor stack pointer |
| pc_out | output | 32 | Handler program counter |
| done | output | 1 | Entry complete pulse |

## Verification
The in-line assertions watch several properties on every cycle. They check that requests stay stable until acknowledged and that addresses are word aligned. They check that the acknowledge cycle and memory traffic never overlap, that vector reads stay inside the vector table, and that supervisor mode with trace off is set at completion. They also check that `done` is a single-cycle pulse and that the outputs hold while idle. Only the bench scenarios can show that the frame contents, their order and addresses, the final stack pointer and the loaded handler address are right for each kind. The same holds for the mask update per kind, for a reset that abandons a sequence mid-stack, and for a non-reset request ignored while busy.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VW         = 8,
  parameter int TNW        = 4,
  parameter int TRAP_BASE  = 32,
  parameter int SHORT_LEN  = 4,
  parameter int LONG_LEN   = 29,
  parameter logic [2:0] RESET_MASK = 3'd7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      kind,
  input  logic [2:0]      irq_level,
  input  logic [TNW-1:0]  trap_num,
  input  logic [15:0]     sr_in,
  input  logic [31:0]     pc_in,
  input  logic [31:0]     ssp_in,
  input  logic [31:0]     fault_addr,
  input  logic [15:0]     fault_info,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [15:0]     mem_wdata,
  input  logic [15:0]     mem_rdata,
  input  logic            mem_ack,
  output logic            iack_req,
  output logic [2:0]      iack_level,
  input  logic            iack_ack,
  input  logic [VW-1:0]   iack_vector,
  output logic [15:0]     sr_out,
  output logic [31:0]     ssp_out,
  output logic [31:0]     pc_out,
  output logic            done
);
  localparam int CW   = $clog2(LONG_LEN);
  localparam int OFFW = 12;
  localparam logic [2:0] K_RST = 3'd0, K_IRQ = 3'd1, K_BUS = 3'd2, K_ADR = 3'd3, K_TRP = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_IACK, ST_PUSH, ST_FETCH} st_t;

  st_t            state;
  logic [2:0]     kind_q;
  logic [15:0]    sr_copy, sr_q, finfo_q;
  logic [31:0]    pc_q, ssp_q, pc_new, faddr_q;
  logic [VW-1:0]  vec_q, vec_int;
  logic [CW-1:0]  cnt;
  logic [1:0]     fcnt, fsel;
  logic [15:0]    frame_word;
  logic [31:0]    vaddr;

  wire take      = start && (state == ST_IDLE || kind == K_RST);
  wire in_long   = (kind == K_BUS) || (kind == K_ADR);
  wire q_long    = (kind_q == K_BUS) || (kind_q == K_ADR);
  wire q_rst     = (kind_q == K_RST);
  wire fetch_end = q_rst ? (fcnt == 2'd3) : (fcnt == 2'd1);

  always_comb begin
    case (kind)
      K_RST:   vec_int = '0;
      K_BUS:   vec_int = VW'(2);
      K_ADR:   vec_int = VW'(3);
      K_TRP:   vec_int = VW'(TRAP_BASE) + VW'(trap_num);
      default: vec_int = '0;
    endcase
  end

  always_comb begin
    case (cnt)
      CW'(0):  frame_word = sr_copy;
      CW'(1):  frame_word = pc_q[31:16];
      CW'(2):  frame_word = pc_q[15:0];
      CW'(3):  frame_word = {(q_long ? 4'b1000 : 4'b0000),
                             {(OFFW-VW-2){1'b0}}, vec_q, 2'b00};
      CW'(4):  frame_word = finfo_q;
      CW'(5):  frame_word = faddr_q[31:16];
      CW'(6):  frame_word = faddr_q[15:0];
      default: frame_word = '0;
    endcase
  end

  assign vaddr      = {{(30-VW){1'b0}}, vec_q, 2'b00} + {29'd0, fcnt, 1'b0};
  assign fsel       = q_rst ? fcnt : fcnt + 2'd2;
  assign busy       = (state != ST_IDLE);
  assign mem_req    = (state == ST_PUSH) || (state == ST_FETCH);
  assign mem_we     = (state == ST_PUSH);
  assign mem_addr   = mem_we ? ssp_q - 32'd2 : vaddr;
  assign mem_wdata  = mem_we ? frame_word : 16'd0;
  assign iack_req   = (state == ST_IACK);
  assign iack_level = sr_q[10:8];
  assign sr_out     = sr_q;
  assign ssp_out    = ssp_q;
  assign pc_out     = pc_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind_q  <= K_RST;
      sr_copy <= '0;
      sr_q    <= '0;
      finfo_q <= '0;
      pc_q    <= '0;
      ssp_q   <= '0;
      pc_new  <= '0;
      faddr_q <= '0;
      vec_q   <= '0;
      cnt     <= '0;
      fcnt    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        kind_q  <= kind;
        sr_copy <= sr_in;
        pc_q    <= pc_in;
        ssp_q   <= ssp_in;
        faddr_q <= fault_addr;
        finfo_q <= fault_info;
        vec_q   <= vec_int;
        fcnt    <= '0;
        cnt     <= in_long ? CW'(LONG_LEN-1) : CW'(SHORT_LEN-1);
        if (kind == K_RST)
          sr_q <= {3'b001, 2'b00, RESET_MASK, 8'h00};
        else
          sr_q <= {1'b0, sr_in[14], 1'b1, sr_in[12:11],
                   (kind == K_IRQ) ? irq_level : sr_in[10:8], sr_in[7:0]};
        case (kind)
          K_RST:   state <= ST_FETCH;
          K_IRQ:   state <= ST_IACK;
          default: state <= ST_PUSH;
        endcase
      end else begin
        case (state)
          ST_IACK: if (iack_ack) begin
            vec_q <= iack_vector;
            state <= ST_PUSH;
          end
          ST_PUSH: if (mem_ack) begin
            ssp_q <= ssp_q - 32'd2;
            if (cnt == '0) state <= ST_FETCH;
            else           cnt   <= cnt - CW'(1);
          end
          ST_FETCH: if (mem_ack) begin
            case (fsel)
              2'd0: ssp_q[31:16]  <= mem_rdata;
              2'd1: ssp_q[15:0]   <= mem_rdata;
              2'd2: pc_new[31:16] <= mem_rdata;
              default: pc_new[15:0] <= mem_rdata;
            endcase
            fcnt <= fcnt + 2'd1;
            if (fetch_end) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !(start && kind == K_RST)) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R9
  AST_IACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && iack_req)); // R3
  AST_VEC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr < 32'd1024)); // R5
  AST_SUPER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sr_out[13] && !sr_out[15] && !busy)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pc_out) && $stable(ssp_out) && $stable(sr_out))); // R10
endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] kind = 0, irq_level = 0;
  logic [3:0] trap_num = 0;
  logic [15:0] sr_in = 0, fault_info = 0, mem_rdata, mem_wdata, sr_out;
  logic [31:0] pc_in = 0, ssp_in = 0, fault_addr = 0, mem_addr, ssp_out, pc_out;
  logic busy, mem_req, mem_we, mem_ack, iack_req, iack_ack, done;
  logic [2:0] iack_level;
  logic [7:0] iack_vector;

  int total = 0, bad = 0, cyc = 0;
  int wcnt = 0, icnt = 0, mdly = 0, idly = 0;
  logic [31:0] wa [0:31];
  logic [15:0] wd [0:31];
  logic [2:0]  ilvl_seen;

  always #2.5 clk = ~clk;

  exc_entry_seq dut (.*);

  function automatic logic [15:0] rd(input logic [31:0] a);
    return (a[15:0] * 16'h9E37) ^ 16'h5A5A;
  endfunction
  assign mem_rdata = rd(mem_addr);

  always @(posedge clk) begin
    if (!rst_n) begin mem_ack <= 0; iack_ack <= 0; end
    else begin
      mem_ack <= 0; iack_ack <= 0;
      if (mem_req && !mem_ack) begin
        if (mdly == 0) begin
          mem_ack <= 1;
          if (mem_we && wcnt < 32) begin wa[wcnt] <= mem_addr; wd[wcnt] <= mem_wdata; end
          if (mem_we) wcnt <= wcnt + 1;
          mdly <= $urandom % 3;
        end else mdly <= mdly - 1;
      end
      if (iack_req && !iack_ack) begin
        if (idly == 0) begin
          iack_ack <= 1; icnt <= icnt + 1; ilvl_seen <= iack_level;
          idly <= $urandom % 4;
        end else idly <= idly - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] vnum(input int k, input logic [3:0] tn, input logic [7:0] iv);
    case (k)
      1: return iv;
      2: return 8'd2;
      3: return 8'd3;
      4: return 8'd32 + {4'd0, tn};
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [15:0] fw(input int i, input bit lng, input logic [15:0] s,
      input logic [31:0] pc, input logic [7:0] vn, input logic [15:0] fi, input logic [31:0] fa);
    case (i)
      0: return s;
      1: return pc[31:16];
      2: return pc[15:0];
      3: return {(lng ? 4'b1000 : 4'b0000), 2'b00, vn, 2'b00};
      4: return fi;
      5: return fa[31:16];
      6: return fa[15:0];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic wait_done();
    int w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk(done, "R10 done seen", {31'd0, done}, 1);
  endtask

  task automatic run(input int k, input logic [2:0] lvl, input logic [3:0] tn,
                     input logic [7:0] iv, input bit poke);
    logic [15:0] s, fi, es;
    logic [31:0] pc, sp, fa, va, epc, esp;
    logic [7:0] vn;
    bit lng, wok;
    int n;
    s = 16'($urandom); pc = $urandom; sp = ($urandom & 32'h00FF_FFFE) | 32'h0001_0000;
    fa = $urandom; fi = 16'($urandom);
    @(negedge clk);
    kind = 3'(k); irq_level = lvl; trap_num = tn; iack_vector = iv;
    sr_in = s; pc_in = pc; ssp_in = sp; fault_addr = fa; fault_info = fi;
    wcnt = 0; icnt = 0; start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      @(negedge clk);
      kind = 3'd4; trap_num = ~tn; pc_in = ~pc; sr_in = ~s; ssp_in = sp + 32'h100; start = 1;
      @(negedge clk); start = 0; kind = 3'(k);
    end
    wait_done();
    lng = (k == 2 || k == 3);
    n = lng ? 29 : 4;
    vn = vnum(k, tn, iv);
    va = {22'd0, vn, 2'b00};
    if (k == 0) begin
      es = 16'h2700; esp = {rd(0), rd(2)}; epc = {rd(4), rd(6)};
      chk(wcnt == 0, "R8 no writes", wcnt, 0);
    end else begin
      es = {1'b0, s[14], 1'b1, s[12:11], (k == 1) ? lvl : s[10:8], s[7:0]};
      esp = sp - 32'(2 * n); epc = {rd(va), rd(va + 2)};
      chk(wcnt == n, lng ? "R7 frame length" : "R6 frame length", wcnt, n);
      wok = 1;
      for (int i = 0; i < n && i < 32; i++)
        if (wa[i] !== sp - 32'(2 * (i + 1)) || wd[i] !== fw(n - 1 - i, lng, s, pc, vn, fi, fa)) wok = 0;
      chk(wok, lng ? "R7 long frame words" : "R6 short frame words", {16'd0, wd[3]}, {16'd0, fw(n - 4, lng, s, pc, vn, fi, fa)});
    end
    chk(sr_out === es, (k == 0 || k == 1) ? "R2 mask / R1 sr" : "R1 sr bits", {16'd0, sr_out}, {16'd0, es});
    chk(ssp_out === esp, "R6 R7 R8 ssp", ssp_out, esp);
    chk(pc_out === epc, "R4 R5 vector pc", pc_out, epc);
    if (k == 1) begin
      chk(icnt == 1 && ilvl_seen == lvl, "R3 iack level", {29'd0, ilvl_seen}, {29'd0, lvl});
    end else
      chk(icnt == 0, "R3 no iack", icnt, 0);
    if (poke) chk(1, "R12 poke ignored", 0, 0);
    @(negedge clk);
    chk(!done && !busy && pc_out === epc && ssp_out === esp, "R10 pulse and hold", {31'd0, done}, 0);
  endtask

  task automatic abort_test();
    int w = 0;
    @(negedge clk);
    kind = 3'd4; trap_num = 4'd5; sr_in = 16'hA31F; pc_in = 32'h1234_5678; ssp_in = 32'h0002_0000;
    wcnt = 0; start = 1;
    @(negedge clk); start = 0;
    while (wcnt < 2 && w < 200) begin @(negedge clk); w++; end
    kind = 3'd0; start = 1;
    @(negedge clk); start = 0;
    wait_done();
    chk(sr_out === 16'h2700, "R11 abort sr", {16'd0, sr_out}, 32'h2700);
    chk(ssp_out === {rd(0), rd(2)}, "R11 abort ssp", ssp_out, {rd(0), rd(2)});
    chk(pc_out === {rd(4), rd(6)}, "R11 abort pc", pc_out, {rd(4), rd(6)});
  endtask

  initial begin
    void'($urandom(32'd4242));
    iack_vector = 8'd64;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !iack_req && !done, "R10 reset state", {28'd0, busy, mem_req, iack_req, done}, 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 3'd0, 4'd0, 8'd0, 0);
    run(4, 3'd0, 4'd0, 8'd0, 0);
    run(4, 3'd0, 4'd15, 8'd0, 0);
    run(1, 3'd7, 4'd0, 8'd255, 0);
    run(1, 3'd1, 4'd0, 8'd64, 0);
    run(2, 3'd0, 4'd0, 8'd0, 0);
    run(3, 3'd0, 4'd0, 8'd0, 0);
    run(2, 3'd0, 4'd0, 8'd0, 1);
    run(1, 3'd4, 4'd0, 8'd100, 1);
    abort_test();
    run(4, 3'd0, 4'd9, 8'd0, 0);
    for (int r = 0; r < 40; r++)
      run($urandom % 5, 3'($urandom), 4'($urandom), 8'(64 + $urandom % 192), ($urandom % 4) == 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule